// File: doc/BRIEF.md
# Bit-Interleaved Justification Multiplexer

This block merges four independent serial tributaries, each running at about 2.048 Mb/s from its own slightly different clock, into one higher-order stream at about 8.448 Mb/s. Each tributary bit arrives with that tributary's own clock-enable strobe and goes into a 16-bit elastic buffer. The output side is paced by a separate output enable. On each enabled cycle it emits one bit of a fixed 848-bit frame. The frame is built from four sets of 212 bits and carries an alignment word, service bits, justification control bits, one justification opportunity per tributary, and payload bits taken from tributaries 1, 2, 3 and 4 in strict rotation.

The output rate is slightly above four times the tributary rate, so a tributary can at times lack a bit when its turn comes. Once per frame, at the first frame bit, a justification controller samples each buffer's fill. A tributary whose buffer is less than half full is stuffed for that frame. The controller announces the stuff in that tributary's three control bits, and the opportunity slot then carries a dummy bit instead of data. Tributary contents are treated as unstructured bits. Sticky per-tributary flags report a buffer that overflowed or underflowed even with justification in place.

Top module: `jmux_top`

## Requirements
- R1: Payload bits are interleaved one bit at a time. A payload slot at offset k within its set carries the next buffered bit of tributary (k mod 4), 0-based. Offsets 0 to 3 map to tributaries 1 to 4.
- R2: The frame is 848 output bits made of four sets of 212. `frame_start` is high for exactly the output cycle that presents frame bit 0.
- R3: Set 1 starts with the alignment word 1111010000, sent left bit first. Its next two bits are service bits sent as 0.
- R4: Sets 2, 3 and 4 start with four control bits, one per tributary in order 1 to 4. Each control bit is 1 when that tributary is stuffed in the current frame and 0 when it is not.
- R5: Set 4 bits 4 to 7 are the opportunity slots for tributaries 1 to 4. A stuffed tributary sends 0 there and its buffer is not read. An unstuffed tributary sends its next data bit.
- R6: The stuff decision for each tributary is taken on the output cycle that sends frame bit 0. The tributary is stuffed when its buffer holds fewer than 8 bits at that moment.
- R7: Each tributary buffer holds 16 bits. Reset recentres it so that it holds 8 bits, all zero.
- R8: A tributary bit is written on every cycle its enable is high, and the tributary's bits leave in the order they were written.
- R9: A write to a full buffer with no read in the same cycle drops the bit and sets that tributary's sticky overflow flag.
- R10: A read from an empty buffer sends 0 and sets that tributary's sticky underflow flag.
- R11: While `out_en` is low, `ser_out` holds its value, `frame_start` is 0, and the frame position does not advance.
- R12: After reset, `ser_out`, `frame_start` and all error flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for both sides |
| rst | input | 1 | Synchronous active-high reset; recentres buffers |
| trib_en | input | 4 | Per-tributary write strobe |
| trib_bit | input | 4 | Per-tributary data bit, taken when its strobe is high |
| out_en | input | 1 | Output bit strobe; one frame bit per high cycle |
| ser_out | output | 1 | Multiplexed serial output, registered |
| frame_start | output | 1 | High while `ser_out` carries frame bit 0 |
| ovf_err | output | 4 | Sticky per-tributary overflow flags |
| unf_err | output | 4 | Sticky per-tributary underflow flags |

## Verification
A wrong frame counter or slot decode shows up within one frame as a misplaced alignment word or a displaced `frame_start`. A wrong stuff decision appears in the same frame, first in the set 2 control bits and then in the opportunity slots of set 4. Buffer pointer faults do not show up at once. They surface as shifted payload data or as flipped error flags once the 8-bit centre margin has been used up, which can take several frames at near-nominal rates. For that reason the bench runs tens of frames and also forces both buffer extremes on purpose.

// File: rtl/jmux_pkg.sv
package jmux_pkg;

    localparam int N_TRIB     = 4;
    localparam int TRIB_W     = $clog2(N_TRIB);
    localparam int SET_BITS   = 212;
    localparam int N_SETS     = 4;
    localparam int SET_W      = $clog2(N_SETS);
    localparam int IDX_W      = $clog2(SET_BITS);
    localparam int FAW_LEN    = 10;
    localparam int SVC_LEN    = 2;
    localparam logic [FAW_LEN-1:0] FAW_WORD = 10'b1111010000;
    localparam int BUF_DEPTH  = 16;

    typedef enum logic [2:0] {
        SK_FAW,
        SK_SVC,
        SK_CTRL,
        SK_OPP,
        SK_PAY
    } slot_kind_e;

    typedef struct packed {
        slot_kind_e          kind;
        logic [TRIB_W-1:0]   trib;
        logic                faw;
    } slot_t;

    function automatic slot_t classify(input logic [SET_W-1:0] set_i,
                                       input logic [IDX_W-1:0] idx_i);
        slot_t s;
        s.kind = SK_PAY;
        s.trib = idx_i[TRIB_W-1:0];
        s.faw  = 1'b0;
        if (set_i == '0) begin
            if (idx_i < IDX_W'(FAW_LEN)) begin
                s.kind = SK_FAW;
                s.faw  = FAW_WORD[(FAW_LEN-1) - int'(idx_i)];
            end else if (idx_i < IDX_W'(FAW_LEN + SVC_LEN)) begin
                s.kind = SK_SVC;
            end
        end else if (idx_i < IDX_W'(N_TRIB)) begin
            s.kind = SK_CTRL;
        end else if (set_i == SET_W'(N_SETS - 1) && idx_i < IDX_W'(2 * N_TRIB)) begin
            s.kind = SK_OPP;
        end
        return s;
    endfunction

endpackage

// File: rtl/jmux_elastic.sv
module jmux_elastic #(
    parameter  int DEPTH = 16,
    localparam int AW    = $clog2(DEPTH),
    localparam int FW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          wr_bit,
    input  logic          rd_en,
    output logic          rd_bit,
    output logic [FW-1:0] fill,
    output logic          ovf,
    output logic          unf
);

    logic [DEPTH-1:0] mem;
    logic [FW-1:0]    wp, rp;
    logic             full, empty, do_rd, do_wr;

    assign fill   = wp - rp;
    assign full   = (fill == FW'(DEPTH));
    assign empty  = (fill == '0);
    assign do_rd  = rd_en && !empty;
    assign do_wr  = wr_en && (!full || do_rd);
    assign rd_bit = empty ? 1'b0 : mem[rp[AW-1:0]];

    always_ff @(posedge clk) begin
        if (rst) begin
            mem <= '0;
            wp  <= FW'(DEPTH / 2);
            rp  <= '0;
            ovf <= 1'b0;
            unf <= 1'b0;
        end else begin
            if (do_wr) begin
                mem[wp[AW-1:0]] <= wr_bit;
                wp <= wp + 1'b1;
            end
            if (do_rd) rp <= rp + 1'b1;
            ovf <= ovf | (wr_en && full && !do_rd);
            unf <= unf | (rd_en && empty);
        end
    end

    AST_FILL_BOUND: assert property (@(posedge clk) disable iff (rst)
        fill <= FW'(DEPTH));                                         // R7
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        ovf |=> ovf);                                                // R9
    AST_UNF_STICKY: assert property (@(posedge clk) disable iff (rst)
        unf |=> unf);                                                // R10
    AST_DROP_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
        wr_en && full && !rd_en |=> fill == FW'(DEPTH));             // R9

endmodule

// File: rtl/jmux_framer.sv
module jmux_framer
    import jmux_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    output logic [SET_W-1:0] set_idx,
    output logic [IDX_W-1:0] bit_idx,
    output logic             first
);

    logic last_bit, last_set;

    assign last_bit = (bit_idx == IDX_W'(SET_BITS - 1));
    assign last_set = (set_idx == SET_W'(N_SETS - 1));
    assign first    = (bit_idx == '0) && (set_idx == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            set_idx <= '0;
            bit_idx <= '0;
        end else if (adv) begin
            if (last_bit) begin
                bit_idx <= '0;
                set_idx <= last_set ? '0 : set_idx + 1'b1;
            end else begin
                bit_idx <= bit_idx + 1'b1;
            end
        end
    end

    AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (rst)
        adv && last_bit && last_set |=> first);                      // R2

endmodule

// File: rtl/jmux_stuffctl.sv
module jmux_stuffctl #(
    parameter  int NT    = 4,
    parameter  int DEPTH = 16,
    localparam int FW    = $clog2(DEPTH) + 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   decide,
    input  logic [NT-1:0][FW-1:0]  fill_i,
    output logic [NT-1:0]          stuff
);

    for (genvar g = 0; g < NT; g++) begin : g_dec
        always_ff @(posedge clk) begin
            if (rst)         stuff[g] <= 1'b0;
            else if (decide) stuff[g] <= (fill_i[g] < FW'(DEPTH / 2));
        end
    end

    AST_STUFF_STABLE: assert property (@(posedge clk) disable iff (rst)
        !decide |=> $stable(stuff));                                 // R6

endmodule

// File: rtl/jmux_top.sv
module jmux_top
    import jmux_pkg::*;
#(
    parameter  int DEPTH = BUF_DEPTH,
    localparam int FW    = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_TRIB-1:0] trib_en,
    input  logic [N_TRIB-1:0] trib_bit,
    input  logic              out_en,
    output logic              ser_out,
    output logic              frame_start,
    output logic [N_TRIB-1:0] ovf_err,
    output logic [N_TRIB-1:0] unf_err
);

    logic [SET_W-1:0]            set_idx;
    logic [IDX_W-1:0]            bit_idx;
    logic                        first;
    logic [N_TRIB-1:0][FW-1:0]   fill;
    logic [N_TRIB-1:0]           ren, rbit, stuff;
    slot_t                       slot;
    logic                        nbit;

    jmux_framer u_framer (
        .clk(clk), .rst(rst), .adv(out_en),
        .set_idx(set_idx), .bit_idx(bit_idx), .first(first)
    );

    jmux_stuffctl #(.NT(N_TRIB), .DEPTH(DEPTH)) u_stuff (
        .clk(clk), .rst(rst), .decide(out_en && first),
        .fill_i(fill), .stuff(stuff)
    );

    assign slot = classify(set_idx, bit_idx);

    for (genvar g = 0; g < N_TRIB; g++) begin : g_trib
        assign ren[g] = out_en && (slot.trib == TRIB_W'(g)) &&
                        ((slot.kind == SK_PAY) || (slot.kind == SK_OPP && !stuff[g]));
        jmux_elastic #(.DEPTH(DEPTH)) u_buf (
            .clk(clk), .rst(rst),
            .wr_en(trib_en[g]), .wr_bit(trib_bit[g]),
            .rd_en(ren[g]), .rd_bit(rbit[g]),
            .fill(fill[g]), .ovf(ovf_err[g]), .unf(unf_err[g])
        );
    end

    always_comb begin
        unique case (slot.kind)
            SK_FAW:  nbit = slot.faw;
            SK_SVC:  nbit = 1'b0;
            SK_CTRL: nbit = stuff[slot.trib];
            SK_OPP:  nbit = stuff[slot.trib] ? 1'b0 : rbit[slot.trib];
            default: nbit = rbit[slot.trib];
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ser_out     <= 1'b0;
            frame_start <= 1'b0;
        end else begin
            frame_start <= out_en && first;
            if (out_en) ser_out <= nbit;
        end
    end

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !out_en |=> $stable(ser_out) && !frame_start);               // R11
    AST_FAW_LEAD: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> ser_out);                                    // R3
    AST_ONE_READ: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ren));                                              // R1
    AST_STUFF_NO_READ: assert property (@(posedge clk) disable iff (rst)
        out_en && slot.kind == SK_OPP && stuff[slot.trib] |-> ren == '0); // R5

endmodule

// File: tb/jmux_top_test.sv
module jmux_top_test;
    import jmux_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int FRAME      = SET_BITS * N_SETS;
    localparam logic [9:0] ALIGN = 10'b1111010000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [N_TRIB-1:0] trib_en  = '0;
    logic [N_TRIB-1:0] trib_bit = '0;
    logic out_en = 1'b0;
    logic ser_out, frame_start;
    logic [N_TRIB-1:0] ovf_err, unf_err;

    jmux_top uut (
        .clk(clk), .rst(rst), .trib_en(trib_en), .trib_bit(trib_bit),
        .out_en(out_en), .ser_out(ser_out), .frame_start(frame_start),
        .ovf_err(ovf_err), .unf_err(unf_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int    vectors = 0;
    int    miscompares = 0;
    bit    done = 1'b0;
    bit    mq [N_TRIB][$];
    bit    m_ovf [N_TRIB];
    bit    m_unf [N_TRIB];
    bit    m_stuff [N_TRIB];
    int    m_pos;
    bit    e_ser, e_fs;
    string e_tag;
    int    wcnt [N_TRIB];
    int    acc  [N_TRIB];

    function automatic bit pat(int i, int k);
        return bit'((((k * (i + 3)) >> 1) ^ (k >> 3) ^ i) & 1);
    endfunction

    task automatic chk(string tag, logic act, bit exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: got %0b expected %0b (frame pos %0d)", tag, act, exp, m_pos);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < N_TRIB; i++) begin
            mq[i].delete();
            repeat (BUF_DEPTH / 2) mq[i].push_back(1'b0);
            m_ovf[i] = 0; m_unf[i] = 0; m_stuff[i] = 0;
            wcnt[i] = 0; acc[i] = 0;
        end
        m_pos = 0; e_ser = 0; e_fs = 0;
    endtask

    task automatic do_reset();
        rst = 1'b1; trib_en = '0; trib_bit = '0; out_en = 1'b0;
        repeat (2) @(negedge clk);
        model_reset();
        chk("R12 ser_out", ser_out, 1'b0);
        chk("R12 frame_start", frame_start, 1'b0);
        for (int i = 0; i < N_TRIB; i++) begin
            chk("R12 ovf", ovf_err[i], 1'b0);
            chk("R12 unf", unf_err[i], 1'b0);
        end
        rst = 1'b0;
    endtask

    function automatic bit pop_bit(int t);
        if (mq[t].size() == 0) begin
            m_unf[t] = 1;
            return 1'b0;
        end
        return mq[t].pop_front();
    endfunction

    task automatic step(bit oe, logic [N_TRIB-1:0] en);
        out_en  = oe;
        trib_en = en;
        for (int i = 0; i < N_TRIB; i++)
            trib_bit[i] = en[i] ? pat(i, wcnt[i]) : 1'b0;
        if (oe) begin
            int s = m_pos / SET_BITS;
            int x = m_pos % SET_BITS;
            if (m_pos == 0)
                for (int i = 0; i < N_TRIB; i++) m_stuff[i] = (mq[i].size() < 8);
            if (s == 0 && x < 10) begin
                e_ser = ALIGN[9 - x]; e_tag = "R3 align";
            end else if (s == 0 && x < 12) begin
                e_ser = 1'b0; e_tag = "R3 service";
            end else if (s != 0 && x < 4) begin
                e_ser = m_stuff[x]; e_tag = "R4/R6 control";
            end else if (s == 3 && x < 8) begin
                if (m_stuff[x - 4]) begin
                    e_ser = 1'b0; e_tag = "R5 stuffed";
                end else begin
                    e_ser = pop_bit(x - 4); e_tag = "R5/R8 opportunity data";
                end
            end else begin
                e_ser = pop_bit(x % 4); e_tag = "R1/R8 payload";
            end
            e_fs  = (m_pos == 0);
            m_pos = (m_pos + 1) % FRAME;
        end else begin
            e_fs = 1'b0; e_tag = "R11 hold";
        end
        for (int i = 0; i < N_TRIB; i++) begin
            if (en[i]) begin
                if (mq[i].size() < BUF_DEPTH) mq[i].push_back(pat(i, wcnt[i]));
                else m_ovf[i] = 1;
                wcnt[i]++;
            end
        end
        @(negedge clk);
        chk(e_tag, ser_out, e_ser);
        chk("R2 frame_start", frame_start, e_fs);
        for (int i = 0; i < N_TRIB; i++) begin
            chk("R9/R7 overflow", ovf_err[i], m_ovf[i]);
            chk("R10/R7 underflow", unf_err[i], m_unf[i]);
        end
    endtask

    task automatic run(int cycles, int r0, int r1, int r2, int r3, int gap);
        int rate [N_TRIB];
        rate[0] = r0; rate[1] = r1; rate[2] = r2; rate[3] = r3;
        for (int c = 0; c < cycles; c++) begin
            logic [N_TRIB-1:0] en;
            for (int i = 0; i < N_TRIB; i++) begin
                acc[i] += rate[i];
                en[i] = (acc[i] >= 65536);
                if (en[i]) acc[i] -= 65536;
            end
            step((gap == 0) || (c % gap != 0), en);
        end
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        // Near-nominal rates, each tributary slightly different: stuff and no-stuff frames mix
        run(30 * FRAME, 15870, 15888, 15895, 15879, 0);
        // Output strobe with gaps: idle cycles must hold the line
        do_reset();
        run(10 * FRAME * 5 / 4, 12700, 12715, 12708, 12690, 5);
        // Extremes: tributary 1 floods its buffer, tributary 2 starves
        do_reset();
        run(3 * FRAME, 65536, 0, 15888, 15888, 0);
        do_reset();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule